// File: doc/BRIEF.md
# UART Interrupt and FIFO-Level Controller

This block is the event-collection and interrupt-gating stage of a serial port. The transmit, receive and modem logic around it raise one-cycle pulses whenever something happens, such as a FIFO draining, a parity fault or a modem line toggling. Each pulse latches a sticky bit in a flag register. A mask register picks which latched flags may raise the single level-high interrupt line. Software acknowledges events by writing ones to the flag register.

Software reaches the block through a plain 32-bit register port. A write takes effect on the clock edge on which the write strobe is sampled, and read data follows the address combinationally. The block also packs the live fill counts of the transmit and receive FIFOs into one read-only level register. Software can poll that register to learn how much room is left before it pushes more bytes, or how many bytes are waiting to be drained.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the flag register, the mask register and `irq` are all 0.
- R2: A pulse on `evt_pulse[i]` sets flag bit i on the next clock edge, whatever the mask holds. The bit map is: 0 transmit holding empty, 1 receive holding full, 2 transmit FIFO almost empty, 3 transmit FIFO empty, 4 receive FIFO almost full, 5 receive FIFO full, 6 transmit underrun, 7 receive overrun, 8 parity fault, 9 framing fault, 10 CTS changed, 11 receive idle timeout, 12 break finished, 13 bus error response.
- R3: A write to the flag register at offset 0x18 clears every flag bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: When a set pulse and a write-1 clear hit the same flag bit on the same edge, the bit ends up set.
- R5: `irq` is 1 exactly when some flag bit is set and its mask bit is also 1. It follows the registered state without any added delay.
- R6: The mask register at offset 0x14 is read/write over bits [13:0]. Bits [31:14] read 0.
- R7: The level register at offset 0x24 reads the transmit count in bits [4:0] and the receive count in bits [12:8]. All other bits read 0, and the counts are the live input values.
- R8: A count above the FIFO depth of 16 is reported as 16. As a result, bit 4 of the transmit field is 1 only when that FIFO is full.
- R9: Writes to the level register and to any unmapped offset leave both the flags and the mask unchanged. Reads of unmapped offsets return 0.
- R10: Flag register bits [31:14] read 0, and writing them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_pulse | input | 14 | One-cycle event pulses, one per flag bit |
| tx_level | input | 5 | Transmit FIFO fill count |
| rx_level | input | 5 | Receive FIFO fill count |
| irq | output | 1 | Level-high interrupt request |

## Verification
The bench aims at the race between an event pulse and a write-1 clear on the same bit. A design where the clear wins would lose that event without any trace. It checks that events latch while their mask bit is 0: a design that gated the set rather than the output would drop events that software enables later. It also checks that a zero in the clear data preserves flags, since plain-write semantics would wipe unrelated pending events. Finally it drives counts at and above the depth and writes to read-only or unmapped offsets. A missing clamp would set the full indicator with a wrong count, and a loose decode would corrupt the mask.

// File: rtl/uic_pkg.sv
package uic_pkg;
    localparam int NUM_EVT  = 14;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int OFS_MASK   = 'h14;
    localparam int OFS_FLAGS  = 'h18;
    localparam int OFS_LEVELS = 'h24;
    typedef logic [NUM_EVT-1:0] evt_vec_t;
endpackage

// File: rtl/uic_flags.sv
module uic_flags
    import uic_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  evt_vec_t evt_i,
    input  logic     clr_en_i,
    input  evt_vec_t clr_mask_i,
    output evt_vec_t flags_o
);
    typedef struct packed {
        evt_vec_t flags;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_en_i)
            st_d.flags = st_d.flags & ~clr_mask_i;
        // set after clear so a simultaneous event survives
        st_d.flags = st_d.flags | evt_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    // R2 R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((flags_o & $past(evt_i)) == $past(evt_i)));

    // R3
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> ((flags_o & $past(clr_mask_i & ~evt_i)) == '0));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_en_i && evt_i == '0) |=> $stable(flags_o));
endmodule

// File: rtl/uic_levels.sv
module uic_levels
    import uic_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int RX_LSB = 8
) (
    input  logic [CNT_W-1:0]  tx_cnt_i,
    input  logic [CNT_W-1:0]  rx_cnt_i,
    output logic [DATA_W-1:0] word_o
);
    localparam int NCH = 2;
    localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

    logic [CNT_W-1:0] raw [NCH];
    logic [CNT_W-1:0] rep [NCH];

    assign raw[0] = tx_cnt_i;
    assign raw[1] = rx_cnt_i;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_comb begin
            rep[c] = (raw[c] > CAP) ? CAP : raw[c];
        end
    end

    always_comb begin
        word_o = '0;
        word_o[CNT_W-1:0]             = rep[0];
        word_o[RX_LSB +: CNT_W]       = rep[1];
    end

    // R8
    always_comb begin
        if (word_o[CNT_W-1] === 1'b1)
            full_flag_chk: assert (word_o[CNT_W-1:0] == CAP);
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic [4:0]        tx_level,
    input  logic [4:0]        rx_level,
    output logic              irq
);
    localparam int PAD_W = DATA_W - NUM_EVT;

    typedef struct packed {
        evt_vec_t mask;
    } top_st_t;

    top_st_t st_d, st_q;

    logic     hit_mask, hit_flags, hit_levels;
    evt_vec_t flags;
    logic [DATA_W-1:0] level_word;

    assign hit_mask   = (reg_addr == ADDR_W'(OFS_MASK));
    assign hit_flags  = (reg_addr == ADDR_W'(OFS_FLAGS));
    assign hit_levels = (reg_addr == ADDR_W'(OFS_LEVELS));

    uic_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_pulse),
        .clr_en_i   (reg_wr && hit_flags),
        .clr_mask_i (reg_wdata[NUM_EVT-1:0]),
        .flags_o    (flags)
    );

    uic_levels #(.DEPTH(16), .CNT_W(5), .RX_LSB(8)) u_levels (
        .tx_cnt_i (tx_level),
        .rx_cnt_i (rx_level),
        .word_o   (level_word)
    );

    always_comb begin
        st_d = st_q;
        if (reg_wr && hit_mask)
            st_d.mask = reg_wdata[NUM_EVT-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (hit_mask)        reg_rdata = {{PAD_W{1'b0}}, st_q.mask};
        else if (hit_flags)  reg_rdata = {{PAD_W{1'b0}}, flags};
        else if (hit_levels) reg_rdata = level_word;
    end

    assign irq = |(flags & st_q.mask);

    // R5
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0));

    // R5
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask == '0) |-> !irq);

    // R9
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && hit_mask) |=> $stable(st_q.mask));
endmodule

// File: tb/sim_uart_irq_ctrl.sv
`timescale 1ns/1ps
module sim_uart_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [13:0] evt_pulse = '0;
    logic [4:0]  tx_level = '0;
    logic [4:0]  rx_level = '0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [7:0] A_MASK = 8'h14, A_FLAGS = 8'h18, A_LVL = 8'h24, A_NONE = 8'h30;

    typedef struct packed {
        logic [13:0] mask;
        logic [13:0] evt;
        logic [13:0] clr;
        logic [13:0] exp_flags;
        logic        exp_irq;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{14'h0001, 14'h0001, 14'h0000, 14'h0001, 1'b1},
        '{14'h0000, 14'h2000, 14'h0000, 14'h2000, 1'b0},
        '{14'h00F0, 14'h0F0F, 14'h0000, 14'h0F0F, 1'b0},
        '{14'h0800, 14'h0F0F, 14'h0F00, 14'h000F, 1'b0},
        '{14'h3FFF, 14'h1555, 14'h0555, 14'h1000, 1'b1},
        '{14'h0400, 14'h0400, 14'h0000, 14'h0400, 1'b1},
        '{14'h0002, 14'h3FFF, 14'h3FFD, 14'h0002, 1'b1}
    };

    always #2.5 clk = ~clk;

    uart_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
        .tx_level(tx_level), .rx_level(rx_level), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [13:0] e);
        @(negedge clk);
        evt_pulse = e;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_FLAGS, d); chk("R1", "flags after reset", d, 32'h0);
        rd(A_MASK, d);  chk("R1", "mask after reset", d, 32'h0);
        chk("R1", "irq after reset", {31'b0, irq}, 32'h0);
        rd(A_LVL, d);   chk("R7", "levels idle", d, 32'h0);

        // Vector table: R2 R3 R5
        foreach (VECS[i]) begin
            wr(A_FLAGS, 32'h3FFF);
            wr(A_MASK, {18'b0, VECS[i].mask});
            pulse(VECS[i].evt);
            wr(A_FLAGS, {18'b0, VECS[i].clr});
            rd(A_FLAGS, d);
            chk("R2 R3", $sformatf("vec %0d flags", i), d, {18'b0, VECS[i].exp_flags});
            chk("R5", $sformatf("vec %0d irq", i), {31'b0, irq}, {31'b0, VECS[i].exp_irq});
        end

        // R4 set beats clear on the same edge
        wr(A_FLAGS, 32'h3FFF);
        wr(A_MASK, 32'h0);
        @(negedge clk);
        evt_pulse = 14'h0020; reg_addr = A_FLAGS; reg_wdata = 32'h20; reg_wr = 1'b1;
        @(negedge clk);
        evt_pulse = '0; reg_wr = 1'b0;
        rd(A_FLAGS, d); chk("R4", "set beats clear", d, 32'h20);

        // R3 writing zero keeps flags
        wr(A_FLAGS, 32'h0);
        rd(A_FLAGS, d); chk("R3", "zero write keeps", d, 32'h20);

        // R5 mask enabling a pending flag raises irq at once
        chk("R5", "masked irq low", {31'b0, irq}, 32'h0);
        wr(A_MASK, 32'h20);
        chk("R5", "irq after enable", {31'b0, irq}, 32'h1);

        // R6 mask width
        wr(A_MASK, 32'hFFFF_FFFF);
        rd(A_MASK, d); chk("R6", "mask readback", d, 32'h3FFF);

        // R10 upper flag bits
        wr(A_FLAGS, 32'h3FFF);
        wr(A_FLAGS, 32'hFFFF_C000);
        rd(A_FLAGS, d); chk("R10", "upper flag bits", d, 32'h0);

        // R9 unmapped and read-only writes ignored
        wr(A_MASK, 32'h0123);
        pulse(14'h0101);
        wr(A_NONE, 32'hFFFF_FFFF);
        wr(A_LVL, 32'hFFFF_FFFF);
        rd(A_MASK, d);  chk("R9", "mask after stray writes", d, 32'h0123);
        rd(A_FLAGS, d); chk("R9", "flags after stray writes", d, 32'h0101);
        rd(A_NONE, d);  chk("R9", "unmapped read", d, 32'h0);

        // R7 R8 level packing and clamp
        tx_level = 5'd16; rx_level = 5'd7;
        rd(A_LVL, d); chk("R7", "tx full rx 7", d, 32'h0000_0710);
        tx_level = 5'd15; rx_level = 5'd16;
        rd(A_LVL, d); chk("R7", "tx 15 rx full", d, 32'h0000_100F);
        tx_level = 5'd20; rx_level = 5'd0;
        rd(A_LVL, d); chk("R8", "tx clamp", d, 32'h0000_0010);
        tx_level = 5'd0; rx_level = 5'd31;
        rd(A_LVL, d); chk("R8", "rx clamp", d, 32'h0000_1000);

        // R1 reset clears again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(A_FLAGS, d); chk("R1", "flags after re-reset", d, 32'h0);
        rd(A_MASK, d);  chk("R1", "mask after re-reset", d, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule